// File: doc/BRIEF.md
# Burst Column Address Generator

This block predicts, one column per clock, the order in which a synchronous DRAM walks the columns of an open row during a read or write burst. A controller or a memory model pulses a start request together with the first column, a burst length code and an order select. From the next cycle on, the block presents one column per cycle with a valid strobe. It raises a last-beat flag on the final beat of a finite burst.

Two orders are supported. In sequential order the column counts upward and wraps inside the aligned block that the burst length defines. In interleaved order each beat is the start column XOR the beat index. A full-page length runs sequentially over all 256 columns of the row, wraps from 255 back to 0, and continues until a stop request ends it. Interleaved full-page requests, and unused length codes, are rejected with a one-cycle illegal pulse, and no beat is produced for them.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first start, `valid_o`, `last_o` and `illegal_o` are low.
- R2: One cycle after a legal start, `valid_o` is high and `col_o` equals the start column sampled with the start.
- R3: In sequential order with burst length BL, beat i carries (start + i) mod BL in the low log2(BL) column bits. The bits above them keep the start column's value.
- R4: In interleaved order (`interleave_i` = 1), beat i carries start column XOR i.
- R5: Length code on `bl_code_i`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. For a finite burst that is not stopped, `valid_o` stays high for exactly BL consecutive cycles.
- R6: `last_o` is high on beat BL-1 of a finite burst and on no other cycle.
- R7: A full-page burst runs sequentially, wraps from column 255 to column 0, never raises `last_o`, and keeps going until stopped.
- R8: When `stop_i` is high in a cycle where `valid_o` is high and no start is requested, the beat on the outputs is the last one, and `valid_o` is low in the next cycle. When no burst is running, `stop_i` has no effect. When start and stop are high together, the start wins.
- R9: A start with code 7 and `interleave_i` = 1, or with codes 4 to 6, makes `illegal_o` high for exactly the next cycle. No beat is produced for it, and any burst that was running is aborted.
- R10: A legal start while a burst is running abandons that burst and begins the new one in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the values below |
| start_col_i | input | 8 | First column of the burst |
| bl_code_i | input | 3 | Burst length code (see R5) |
| interleave_i | input | 1 | 1 selects interleaved order, 0 sequential |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is on `col_o` |
| last_o | output | 1 | Current beat is the final beat of a finite burst |
| illegal_o | output | 1 | The previous cycle's start was rejected |

## Verification
The bench targets start columns that are not aligned to the burst block, such as 0x37 and 0xFD. A design that carries out of the low bits instead of wrapping would leave the aligned block on those columns. It also runs a full-page burst across the 255-to-0 boundary, where an off-by-one beat counter would either stop early or raise a spurious last flag. Other cases are a stop on the same cycle as a start, a stop while idle, an illegal request that arrives mid-burst, and a restart on the cycle of a last beat. Each of these exposes a priority mistake as an extra or missing valid beat.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    localparam int BL_CODE_W    = 3;
    localparam int MAX_FIN_CODE = 3;
    localparam logic [BL_CODE_W-1:0] CODE_PAGE = 3'd7;

    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [BL_CODE_W-1:0] code_i,
    input  logic                 ilv_i,
    output logic [COL_W-1:0]     mask_o,
    output logic                 full_o,
    output logic                 legal_o
);
    logic finite;

    always_comb begin
        finite  = (int'(code_i) <= MAX_FIN_CODE);
        full_o  = (code_i == CODE_PAGE);
        legal_o = finite || (full_o && !ilv_i);
        for (int b = 0; b < COL_W; b++) begin
            mask_o[b] = full_o || (finite && (b < int'(code_i)));
        end
    end

    // block mask must be a contiguous run of low ones
    always_comb begin
        if (legal_o) begin
            assert_mask_contig_R5: assert (((mask_o + COL_W'(1)) & mask_o) == '0);
        end
    end
endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    always_comb begin
        sum = base_i + beat_i;
        if (order_i == ORDER_ILV) begin
            col_o = base_i ^ (beat_i & mask_i);
        end else begin
            col_o = (base_i & ~mask_i) | (sum & mask_i);
        end
    end

    // in either order the column never leaves the aligned block
    always_comb begin
        assert_col_in_block_R4: assert (((col_o ^ base_i) & ~mask_i) == '0);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [COL_W-1:0]     start_col_i,
    input  logic [BL_CODE_W-1:0] bl_code_i,
    input  logic                 interleave_i,
    input  logic                 stop_i,
    output logic [COL_W-1:0]     col_o,
    output logic                 valid_o,
    output logic                 last_o,
    output logic                 illegal_o
);
    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        order_e           order;
        logic             full;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] col;
        logic             last;
        logic             illegal;
    } state_t;

    state_t st_d, st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_legal;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] step_col;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i  (bl_code_i),
        .ilv_i   (interleave_i),
        .mask_o  (dec_mask),
        .full_o  (dec_full),
        .legal_o (dec_legal)
    );

    assign beat_inc = st_q.beat + COL_W'(1);

    bcg_col_calc #(.COL_W(COL_W)) u_calc (
        .base_i  (st_q.base),
        .mask_i  (st_q.mask),
        .beat_i  (beat_inc),
        .order_i (st_q.order),
        .col_o   (step_col)
    );

    always_comb begin
        st_d         = st_q;
        st_d.illegal = 1'b0;
        if (start_i) begin
            if (dec_legal) begin
                st_d.active = 1'b1;
                st_d.base   = start_col_i;
                st_d.mask   = dec_mask;
                st_d.order  = order_e'(interleave_i);
                st_d.full   = dec_full;
                st_d.beat   = '0;
                st_d.col    = start_col_i;
                st_d.last   = !dec_full && (dec_mask == '0);
            end else begin
                st_d.active  = 1'b0;
                st_d.last    = 1'b0;
                st_d.illegal = 1'b1;
            end
        end else if (st_q.active) begin
            if (stop_i || st_q.last) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
            end else begin
                st_d.beat = beat_inc;
                st_d.col  = step_col;
                st_d.last = !st_q.full && (beat_inc == st_q.mask);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o     = st_q.col;
    assign valid_o   = st_q.active;
    assign last_o    = st_q.last;
    assign illegal_o = st_q.illegal;

    assert_last_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_page_never_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.full) |-> !last_o);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i && !start_i) |=> !valid_o);

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !valid_o);

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dec_legal) |=> (valid_o && col_o == $past(start_col_i)));

    assert_no_ilv_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !(st_q.full && st_q.order == ORDER_ILV));
endmodule

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o, last_o, illegal_o;

    always #10 clk = ~clk;

    burst_col_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .interleave_i(interleave_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .illegal_o(illegal_o)
    );

    int    nvec = 0;
    int    nfail = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // behavioural reference
    bit m_active = 0, m_illegal = 0, m_full = 0, m_ilv = 0;
    int m_base = 0, m_beat = 0, m_bl = 1;

    function automatic int exp_col();
        int blk;
        if (m_full) return (m_base + m_beat) % 256;
        if (m_ilv)  return m_base ^ m_beat;
        blk = (m_base / m_bl) * m_bl;
        return blk + ((m_base - blk + m_beat) % m_bl);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_illegal = 0;
        end else begin
            m_illegal = 0;
            if (start_i) begin
                int  bl;
                bit  bad;
                bad = 0; bl = 1;
                case (int'(bl_code_i))
                    0: bl = 1;
                    1: bl = 2;
                    2: bl = 4;
                    3: bl = 8;
                    7: bl = 256;
                    default: bad = 1;
                endcase
                if (bl_code_i == 3'd7 && interleave_i) bad = 1;
                if (bad) begin
                    m_active = 0; m_illegal = 1;
                end else begin
                    m_active = 1; m_beat = 0; m_bl = bl;
                    m_full = (bl_code_i == 3'd7); m_ilv = interleave_i;
                    m_base = int'(start_col_i);
                end
            end else if (m_active) begin
                if (stop_i || (!m_full && m_beat == m_bl - 1)) m_active = 0;
                else m_beat = m_beat + 1;
            end
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        nvec++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            string ctag;
            chk(cur_tag, "valid", int'(valid_o), int'(m_active));
            chk("R6", "last", int'(last_o),
                int'(m_active && !m_full && m_beat == m_bl - 1));
            chk("R9", "illegal", int'(illegal_o), int'(m_illegal));
            if (m_active) begin
                if (m_beat == 0)  ctag = "R2";
                else if (m_full)  ctag = "R7";
                else if (m_ilv)   ctag = "R4";
                else              ctag = "R3";
                chk(ctag, "col", int'(col_o), exp_col());
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic go(int col, int code, bit ilv, bit stp);
        @(negedge clk); #1;
        start_i = 1; start_col_i = 8'(col); bl_code_i = 3'(code);
        interleave_i = ilv; stop_i = stp;
        @(negedge clk); #1;
        start_i = 0; stop_i = 0;
    endtask

    task automatic stop_pulse();
        @(negedge clk); #1;
        stop_i = 1;
        @(negedge clk); #1;
        stop_i = 0;
    endtask

    initial begin
        int cols[4] = '{8'h00, 8'h37, 8'hFD, 8'h5A};
        cur_tag = "R1";
        idle(3);
        rst_n = 1;
        idle(3);

        // finite lengths, both orders, aligned and unaligned starts
        cur_tag = "R5";
        for (int o = 0; o < 2; o++)
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < 4; k++) begin
                    go(cols[k], c, o[0], 0);
                    idle(10);
                end

        // full page across the wrap, then stopped
        cur_tag = "R7";
        go(8'hFB, 7, 0, 0);
        idle(12);
        stop_pulse();
        idle(3);
        go(8'h10, 7, 0, 0);
        idle(260);
        stop_pulse();
        idle(3);

        // stop mid burst, stop while idle, stop together with start
        cur_tag = "R8";
        go(8'h23, 3, 0, 0);
        idle(2);
        stop_pulse();
        idle(4);
        stop_pulse();
        idle(3);
        go(8'h46, 2, 1, 1);
        idle(6);

        // illegal requests, including one that aborts a running burst
        cur_tag = "R9";
        go(8'h40, 7, 1, 0);
        idle(3);
        go(8'h40, 5, 0, 0);
        idle(3);
        go(8'h81, 3, 1, 0);
        idle(2);
        go(8'h81, 6, 1, 0);
        idle(5);

        // restart while running and restart on the last beat
        cur_tag = "R10";
        go(8'hC5, 3, 0, 0);
        idle(2);
        go(8'h1E, 2, 1, 0);
        idle(2);
        go(8'h09, 1, 0, 0);
        idle(4);
        go(8'hE7, 7, 0, 0);
        idle(5);
        go(8'h02, 0, 0, 0);
        idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog R1..all actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule